// File: doc/BRIEF.md
# Serial Receive Packet Engine with CRC-16 Check

This block sits behind a demodulator and bit-timing recovery stage. It accepts one received data bit per strobe and frames it. First it waits for a run of alternating bits that marks a preamble. It then hunts for a programmable synchronisation pattern, and after that it collects the payload into bytes. Each byte is presented on a byte-wide write port that feeds an external receive FIFO.

The frame length comes from one of two sources: a fixed configured value, or a length byte that immediately follows the sync pattern. A CRC-16 is accumulated over the framed bytes and compared with the two trailing CRC bytes. The outcome is reported as a one-cycle "packet good" or "CRC error" pulse. After any completed or aborted frame the engine returns to hunting on its own, so a host only has to drain the FIFO and watch the two result pulses.

Top module: `pkt_rx_engine`

## Requirements
- R1: After reset `fifoWrEn`, `fifoWrData`, `pktOk` and `crcErr` are all 0 and the engine is hunting.
- R2: With `preambleEn`=1 the sync search starts only after `preambleBits` consecutive alternating bits (default 16; a 0x55 byte sent MSB first gives 0,1,0,1,...). A shorter alternating run followed by a valid frame yields no byte and no event.
- R3: With `preambleEn`=0 the engine hunts for the sync pattern alone, without any preamble.
- R4: `syncLen`=n selects an (n+1)-byte sync pattern. The pattern is taken from `syncWord[8(n+1)-1:0]`, and the most significant of those bits is first on air. The default is n=1 with the pattern 0x2D then 0xD4.
- R5: With `varLenEn`=1 the first byte after the sync pattern is the payload length. With `varLenEn`=0 the payload length is `fixedLen`, and no length byte is sent.
- R6: Bits are assembled MSB first. Each payload byte produces one `fifoWrEn` pulse, with the byte on `fifoWrData`, in the cycle after the strobe of its last bit. Exactly the payload length is written, for lengths 1 to 64.
- R7: A length byte of 0 or greater than 64 aborts the frame. No FIFO write and no event follow, and the engine returns to hunting so that the next frame is received.
- R8: The CRC covers the length byte (when present) and the payload. It uses the polynomial 0x8005 (x^16+x^15+x^2+1), is processed MSB first, is seeded with 0xFFFF and is not reflected. The received CRC arrives high byte first. On a match, `pktOk` pulses for one cycle, one cycle after the last CRC bit strobe.
- R9: On a CRC mismatch, `crcErr` pulses for one cycle instead of `pktOk`. After either result the engine hunts again and receives the next frame.
- R10: Cycles with `bitValid`=0 change nothing. Frames sent with idle cycles between bits are received exactly like back-to-back frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitValid | input | 1 | Strobe: `bitIn` carries a new bit |
| bitIn | input | 1 | Demodulated data bit |
| preambleEn | input | 1 | 1: qualify a preamble before the sync search |
| preambleBits | input | 8 | Alternating bits required to qualify the preamble (2 or more) |
| syncLen | input | 2 | Sync pattern length minus one, in bytes |
| syncWord | input | 32 | Sync pattern, right-aligned |
| varLenEn | input | 1 | 1: length byte follows the sync pattern |
| fixedLen | input | 7 | Payload length in fixed mode (1 to 64) |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 8 | Payload byte to write |
| pktOk | output | 1 | One-cycle pulse: CRC matched |
| crcErr | output | 1 | One-cycle pulse: CRC mismatch |

## Verification
The bench builds the engine with its default parameters: a 64-byte maximum payload, a sync pattern of up to 4 bytes and an 8-bit preamble counter. With these values it can send a full 64-byte frame, and a length byte of 65 lands just past the limit. Both the widest and the narrowest sync masks can be exercised, as well as a preamble run that falls below the 16-bit threshold. Frames are sent both back to back and with idle gaps between bit strobes.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  typedef enum logic [2:0] {
    ST_PRE, ST_SYNC, ST_LEN, ST_PAY, ST_CRC_HI, ST_CRC_LO
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic preRun;
    logic syncRun;
    logic asmRun;
    logic crcRun;
    logic takeLen;
    logic pushByte;
    logic takeCrcHi;
    logic judge;
  } rxCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic preambleOk;
    logic syncHit;
    logic byteDone;
    logic lenBad;
    logic lastByte;
  } rxStat_t;

  localparam logic [15:0] CRC_POLY = 16'h8005;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

endpackage

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
  import pkt_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    preambleEn,
  input  logic    varLenEn,
  input  rxStat_t stat,
  output rxCtl_t  ctl
);

  rxState_t st, stNext, huntSt;

  assign huntSt = preambleEn ? ST_PRE : ST_SYNC;

  always_comb begin
    stNext = st;
    unique case (st)
      ST_PRE:    if (!preambleEn || stat.preambleOk) stNext = ST_SYNC;
      ST_SYNC:   if (stat.syncHit) stNext = varLenEn ? ST_LEN : ST_PAY;
      ST_LEN:    if (stat.byteDone) stNext = stat.lenBad ? huntSt : ST_PAY;
      ST_PAY:    if (stat.byteDone && stat.lastByte) stNext = ST_CRC_HI;
      ST_CRC_HI: if (stat.byteDone) stNext = ST_CRC_LO;
      ST_CRC_LO: if (stat.byteDone) stNext = huntSt;
      default:   stNext = huntSt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_PRE;
    else       st <= stNext;
  end

  always_comb begin
    ctl           = '0;
    ctl.preRun    = (st == ST_PRE);
    ctl.syncRun   = (st == ST_SYNC);
    ctl.asmRun    = (st == ST_LEN) || (st == ST_PAY) || (st == ST_CRC_HI) || (st == ST_CRC_LO);
    ctl.crcRun    = (st == ST_LEN) || (st == ST_PAY);
    ctl.takeLen   = (st == ST_LEN) && stat.byteDone && !stat.lenBad;
    ctl.pushByte  = (st == ST_PAY) && stat.byteDone;
    ctl.takeCrcHi = (st == ST_CRC_HI) && stat.byteDone;
    ctl.judge     = (st == ST_CRC_LO) && stat.byteDone;
  end

  // R2
  pre_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_PRE) |=> (st == ST_PRE || st == ST_SYNC));

  // R7
  len_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_LEN && stat.byteDone && stat.lenBad) |=> (st == ST_PRE || st == ST_SYNC));

  // R9
  pkt_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_CRC_LO && stat.byteDone) |=> (st == ST_PRE || st == ST_SYNC));

endmodule

// File: rtl/pkt_rx_datapath.sv
module pkt_rx_datapath
  import pkt_rx_pkg::*;
#(
  parameter  int MAX_LEN    = 64,
  parameter  int SYNC_BYTES = 4,
  parameter  int PRE_W      = 8,
  localparam int SYNC_W     = 8 * SYNC_BYTES,
  localparam int SEL_W      = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1,
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic [PRE_W-1:0]  preambleBits,
  input  logic [SEL_W-1:0]  syncLen,
  input  logic [SYNC_W-1:0] syncWord,
  input  logic [LEN_W-1:0]  fixedLen,
  input  rxCtl_t            ctl,
  output rxStat_t           stat,
  output logic              fifoWrEn,
  output logic [7:0]        fifoWrData,
  output logic              pktOk,
  output logic              crcErr
);

  logic [PRE_W-1:0]  runCnt;
  logic              lastBit, haveBit;
  logic [SYNC_W-1:0] syncSh, syncNext, syncMask;
  logic [2:0]        bitCnt;
  logic [7:0]        byteSh, byteNext, crcHi;
  logic [15:0]       crc, crcNext;
  logic [LEN_W-1:0]  payLen, byteCount;
  logic              crcMatch;

  // sync compare mask, one byte lane per generate slice
  for (genvar i = 0; i < SYNC_BYTES; i++) begin : g_mask
    assign syncMask[8*i +: 8] = (int'(syncLen) >= i) ? 8'hFF : 8'h00;
  end

  assign syncNext = {syncSh[SYNC_W-2:0], bitIn};
  assign byteNext = {byteSh[6:0], bitIn};
  assign crcNext  = {crc[14:0], 1'b0} ^ ((crc[15] ^ bitIn) ? CRC_POLY : 16'h0000);
  assign crcMatch = ({crcHi, byteNext} == crc);

  always_comb begin
    stat.preambleOk = ctl.preRun && bitValid && haveBit && (bitIn != lastBit) &&
                      (({1'b0, runCnt} + (PRE_W+1)'(1)) >= {1'b0, preambleBits});
    stat.syncHit    = ctl.syncRun && bitValid &&
                      ((syncNext & syncMask) == (syncWord & syncMask));
    stat.byteDone   = ctl.asmRun && bitValid && (bitCnt == 3'd7);
    stat.lenBad     = (byteNext == 8'h00) || ({1'b0, byteNext} > 9'(MAX_LEN));
    stat.lastByte   = (({1'b0, byteCount} + (LEN_W+1)'(1)) == {1'b0, payLen});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt     <= '0;
      lastBit    <= 1'b0;
      haveBit    <= 1'b0;
      syncSh     <= '0;
      bitCnt     <= '0;
      byteSh     <= '0;
      crc        <= CRC_SEED;
      payLen     <= '0;
      byteCount  <= '0;
      crcHi      <= '0;
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
      pktOk      <= 1'b0;
      crcErr     <= 1'b0;
    end else begin
      // preamble run tracking
      if (!ctl.preRun) begin
        haveBit <= 1'b0;
        runCnt  <= '0;
      end else if (bitValid) begin
        lastBit <= bitIn;
        haveBit <= 1'b1;
        if (haveBit && (bitIn != lastBit))
          runCnt <= (runCnt == {PRE_W{1'b1}}) ? runCnt : runCnt + PRE_W'(1);
        else
          runCnt <= PRE_W'(1);
      end
      // sync search shifter
      if (!ctl.syncRun)  syncSh <= '0;
      else if (bitValid) syncSh <= syncNext;
      // byte assembly
      if (!ctl.asmRun) begin
        bitCnt <= '0;
      end else if (bitValid) begin
        bitCnt <= bitCnt + 3'd1;
        byteSh <= byteNext;
      end
      // CRC accumulation
      if (!ctl.asmRun)                 crc <= CRC_SEED;
      else if (ctl.crcRun && bitValid) crc <= crcNext;
      // length
      if (stat.syncHit) payLen <= fixedLen;
      if (ctl.takeLen)  payLen <= byteNext[LEN_W-1:0];
      if (!ctl.asmRun)       byteCount <= '0;
      else if (ctl.pushByte) byteCount <= byteCount + LEN_W'(1);
      if (ctl.takeCrcHi) crcHi <= byteNext;
      // outputs
      fifoWrEn <= ctl.pushByte;
      if (ctl.pushByte) fifoWrData <= byteNext;
      pktOk  <= ctl.judge && crcMatch;
      crcErr <= ctl.judge && !crcMatch;
    end
  end

  // R6
  wr_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (byteCount != '0) && (byteCount <= payLen));

  // R8
  crc_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.syncRun && !stat.syncHit) |=> (crc == CRC_SEED));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && ctl.asmRun) |=> $stable(bitCnt) && $stable(crc));

endmodule

// File: rtl/pkt_rx_engine.sv
module pkt_rx_engine
  import pkt_rx_pkg::*;
#(
  parameter  int MAX_LEN    = 64,
  parameter  int SYNC_BYTES = 4,
  parameter  int PRE_W      = 8,
  localparam int SYNC_W     = 8 * SYNC_BYTES,
  localparam int SEL_W      = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1,
  localparam int LEN_W      = $clog2(MAX_LEN + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              preambleEn,
  input  logic [PRE_W-1:0]  preambleBits,
  input  logic [SEL_W-1:0]  syncLen,
  input  logic [SYNC_W-1:0] syncWord,
  input  logic              varLenEn,
  input  logic [LEN_W-1:0]  fixedLen,
  output logic              fifoWrEn,
  output logic [7:0]        fifoWrData,
  output logic              pktOk,
  output logic              crcErr
);

  rxCtl_t  ctl;
  rxStat_t stat;

  pkt_rx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .preambleEn (preambleEn),
    .varLenEn   (varLenEn),
    .stat       (stat),
    .ctl        (ctl)
  );

  pkt_rx_datapath #(
    .MAX_LEN    (MAX_LEN),
    .SYNC_BYTES (SYNC_BYTES),
    .PRE_W      (PRE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .bitValid     (bitValid),
    .bitIn        (bitIn),
    .preambleBits (preambleBits),
    .syncLen      (syncLen),
    .syncWord     (syncWord),
    .fixedLen     (fixedLen),
    .ctl          (ctl),
    .stat         (stat),
    .fifoWrEn     (fifoWrEn),
    .fifoWrData   (fifoWrData),
    .pktOk        (pktOk),
    .crcErr       (crcErr)
  );

endmodule

// File: tb/pkt_rx_engine_bench.sv
module pkt_rx_engine_bench;

  typedef byte unsigned bytes_t[$];

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic        preambleEn = 1'b1;
  logic [7:0]  preambleBits = 8'd16;
  logic [1:0]  syncLen = 2'd1;
  logic [31:0] syncWord = 32'h0000_2DD4;
  logic        varLenEn = 1'b1;
  logic [6:0]  fixedLen = 7'd8;
  logic        fifoWrEn, pktOk, crcErr;
  logic [7:0]  fifoWrData;

  int errors = 0, checks = 0;
  bit done = 0;
  byte unsigned rxBuf[$];
  int okCnt = 0, errCnt = 0;

  always #4 clk = ~clk;

  pkt_rx_engine u_pkt_rx_engine (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .preambleEn(preambleEn), .preambleBits(preambleBits), .syncLen(syncLen),
    .syncWord(syncWord), .varLenEn(varLenEn), .fixedLen(fixedLen),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .pktOk(pktOk), .crcErr(crcErr)
  );

  always @(negedge clk) if (rstN) begin
    if (fifoWrEn) rxBuf.push_back(fifoWrData);
    if (pktOk)    okCnt++;
    if (crcErr)   errCnt++;
  end

  task automatic check(bit cond, string req, string what, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc16(bytes_t d);
    logic [15:0] c = 16'hFFFF;
    foreach (d[i]) for (int k = 7; k >= 0; k--) begin
      logic fb = c[15] ^ d[i][k];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  function automatic bytes_t mkPay(int n, int seed);
    bytes_t p;
    for (int i = 0; i < n; i++) p.push_back(8'((i * 37 + seed) & 8'hFF));
    return p;
  endfunction

  function automatic bytes_t mkFrame(int preLen, bytes_t sync, bit useLen, int lenVal,
                                     bytes_t pay, bit badCrc);
    bytes_t f, cov;
    logic [15:0] c;
    for (int i = 0; i < preLen; i++) f.push_back(8'h55);
    foreach (sync[i]) f.push_back(sync[i]);
    if (useLen) begin f.push_back(8'(lenVal)); cov.push_back(8'(lenVal)); end
    foreach (pay[i]) begin f.push_back(pay[i]); cov.push_back(pay[i]); end
    c = crc16(cov);
    if (badCrc) c = c ^ 16'h0100;
    f.push_back(c[15:8]);
    f.push_back(c[7:0]);
    return f;
  endfunction

  task automatic sendFrame(bytes_t f, int gap);
    foreach (f[i]) for (int k = 7; k >= 0; k--) begin
      @(negedge clk);
      bitIn = f[i][k];
      bitValid = 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        bitValid = 1'b0;
      end
    end
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic clearRx();
    repeat (4) @(negedge clk);
    rxBuf.delete();
    okCnt = 0;
    errCnt = 0;
  endtask

  task automatic expectRx(string req, bytes_t exp, int expOk, int expErr);
    bit same;
    repeat (4) @(negedge clk);
    check(rxBuf.size() == exp.size(), req, "byte count", rxBuf.size(), exp.size());
    same = (rxBuf.size() == exp.size());
    if (same) foreach (exp[i]) if (rxBuf[i] != exp[i]) begin
      check(0, req, $sformatf("byte %0d", i), rxBuf[i], exp[i]);
      same = 0;
    end
    if (same) checks++;
    check(okCnt == expOk, req, "pktOk pulses", okCnt, expOk);
    check(errCnt == expErr, req, "crcErr pulses", errCnt, expErr);
  endtask

  bytes_t syncDef = '{8'h2D, 8'hD4};
  bytes_t noPay = '{};

  task automatic testReset();
    check(fifoWrEn == 0 && pktOk == 0 && crcErr == 0 && fifoWrData == 0, "R1",
          "outputs after reset", {fifoWrEn, pktOk, crcErr, fifoWrData}, 0);
  endtask

  task automatic testVarGood();  // R5 R6 R8
    bytes_t p = mkPay(5, 3);
    clearRx();
    sendFrame(mkFrame(4, syncDef, 1, 5, p, 0), 0);
    expectRx("R8", p, 1, 0);
  endtask

  task automatic testBadCrc();  // R9: error then recovery
    bytes_t p = mkPay(4, 90);
    bytes_t q = mkPay(2, 11);
    bytes_t both;
    clearRx();
    sendFrame(mkFrame(4, syncDef, 1, 4, p, 1), 0);
    expectRx("R9", p, 0, 1);
    clearRx();
    sendFrame(mkFrame(4, syncDef, 1, 2, q, 0), 0);
    expectRx("R9", q, 1, 0);
  endtask

  task automatic testFixed();  // R5
    bytes_t p = mkPay(3, 200);
    varLenEn = 0;
    fixedLen = 7'd3;
    clearRx();
    sendFrame(mkFrame(4, syncDef, 0, 0, p, 0), 0);
    expectRx("R5", p, 1, 0);
    varLenEn = 1;
  endtask

  task automatic testLenAbort();  // R7
    bytes_t p = mkPay(6, 7);
    clearRx();
    sendFrame(mkFrame(4, syncDef, 1, 0, mkPay(2, 1), 0), 0);
    expectRx("R7", noPay, 0, 0);
    clearRx();
    sendFrame(mkFrame(4, syncDef, 1, 65, mkPay(3, 1), 0), 0);
    expectRx("R7", noPay, 0, 0);
    clearRx();
    sendFrame(mkFrame(4, syncDef, 1, 6, p, 0), 0);
    expectRx("R7", p, 1, 0);
  endtask

  task automatic testShortPre();  // R2
    bytes_t p = mkPay(3, 17);
    clearRx();
    sendFrame(mkFrame(1, syncDef, 1, 3, '{8'h11, 8'h22, 8'h33}, 0), 0);
    expectRx("R2", noPay, 0, 0);
    clearRx();
    sendFrame(mkFrame(3, syncDef, 1, 3, p, 0), 0);
    expectRx("R2", p, 1, 0);
  endtask

  task automatic testNoPre();  // R3
    bytes_t p = mkPay(4, 60);
    bytes_t f;
    preambleEn = 0;
    clearRx();
    f = mkFrame(0, syncDef, 1, 4, p, 0);
    f.push_front(8'hFF);
    f.push_front(8'h00);
    sendFrame(f, 0);
    expectRx("R3", p, 1, 0);
  endtask

  task automatic testSyncLens();  // R4
    bytes_t p = mkPay(7, 44);
    bytes_t q = mkPay(2, 99);
    preambleEn = 0;
    syncLen = 2'd0;
    syncWord = 32'h0000_00A7;
    clearRx();
    sendFrame(mkFrame(0, '{8'hA7}, 1, 2, q, 0), 0);
    expectRx("R4", q, 1, 0);
    preambleEn = 1;
    syncLen = 2'd3;
    syncWord = 32'h930B_51DE;
    clearRx();
    sendFrame(mkFrame(4, '{8'h93, 8'h0B, 8'h51, 8'hDE}, 1, 7, p, 0), 0);
    expectRx("R4", p, 1, 0);
    syncLen = 2'd1;
    syncWord = 32'h0000_2DD4;
  endtask

  task automatic testMaxGap();  // R6 R10
    bytes_t p = mkPay(64, 5);
    clearRx();
    sendFrame(mkFrame(4, syncDef, 1, 64, p, 0), 2);
    expectRx("R10", p, 1, 0);
    check(rxBuf.size() == 64, "R6", "max payload size", rxBuf.size(), 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testVarGood();
    testBadCrc();
    testFixed();
    testLenAbort();
    testShortPre();
    testNoPre();
    testSyncLens();
    testMaxGap();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule